// File: doc/BRIEF.md
# Four-Channel DMA Register Bank

This block holds the programming state of a four-channel DMA controller and exposes it on a byte-wide I/O bus with a 4-bit register index. Each channel has a 16-bit start address and a 16-bit transfer count. Each of these values is kept twice: a base copy that the bus programs, and a current copy that the channel engine advances. Each channel also has a mask bit and a terminal-count flag. The per-channel engines that generate addresses and move data sit outside this block. They report progress by loading new current values, and they raise a one-cycle pulse when a channel reaches its terminal count.

The 16-bit registers are reached one byte at a time. A single low/high byte pointer is shared by every channel and by both reads and writes, and each access to an address or count register moves it on. Separate command indices reset that pointer, perform a master clear, unmask all channels, or load all four masks at once. A status index reports the terminal-count flags and the live request lines. Reading the status index also clears the terminal-count flags.

Top module: `dma_chan_regs`

## Requirements
- R1: Bus index 2n selects the address register of channel n, and index 2n+1 selects its count register, for n = 0..3.
- R2: One byte pointer is shared by all address and count accesses, both reads and writes. The first access after the pointer is cleared uses bits 7:0, the next uses bits 15:8, and every further access alternates.
- R3: A bus write to an address or count register loads the addressed byte into both the base copy and the current copy, and leaves the other byte of each copy unchanged.
- R4: Bus reads of address and count registers return the current copy. A pulse on `eng_ld[n]` loads the current address and count of channel n from the engine inputs and leaves the base copies unchanged. If a bus write to the same register arrives in the same cycle, the bus write takes precedence.
- R5: A write to index 0xC returns the byte pointer to the low byte.
- R6: A write to index 0xD sets all four masks, clears all terminal-count flags and returns the byte pointer to the low byte.
- R7: A write to index 0xE clears all four masks.
- R8: A write to index 0xF loads mask n from data bit n.
- R9: A read of index 0x8 returns the terminal-count flags in bits 3:0 and the request inputs in bits 7:4, using the values present in the read cycle. After the read, every terminal-count flag is cleared.
- R10: A pulse on `tc_set[n]` sets the terminal-count flag of channel n. This set wins over a status-read clear or a master clear in the same cycle.
- R11: Reads of indices 0x9 to 0xF return 0. Writes to indices 0x8 to 0xB have no effect. Neither kind of access moves the byte pointer.
- R12: A synchronous reset sets all masks, clears the flags, registers, byte pointer and read data.
- R13: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_idx | input | 4 | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| chan_req | input | 4 | Live request line of each channel |
| tc_set | input | 4 | Terminal-count pulse from each engine |
| eng_ld | input | 4 | Engine load strobe for current address and count |
| eng_addr | input | 64 | Engine current address, 16 bits per channel |
| eng_cnt | input | 64 | Engine current count, 16 bits per channel |
| mask_o | output | 4 | Channel masks |
| tc_o | output | 4 | Terminal-count flags |
| base_addr_o | output | 64 | Base address, 16 bits per channel |
| base_cnt_o | output | 64 | Base count, 16 bits per channel |
| cur_addr_o | output | 64 | Current address, 16 bits per channel |
| cur_cnt_o | output | 64 | Current count, 16 bits per channel |

## Verification
Every register result of an access is due one cycle after the strobe. Read data, masks, flags, the stored words and the byte pointer all change at the clock edge that captures the strobe. The driver presents each access just after a falling edge and releases it at the next falling edge. The monitor takes a read result at the falling edge that follows the capturing rising edge, so it samples half a cycle after the change. Direct checks of masks, flags and register words are made at that same falling edge. Effects on the byte pointer show up only through the byte that a later access reaches.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
  parameter int CH_N   = 4;
  parameter int BYTE_W = 8;
  parameter int IDX_W  = 4;
  localparam int WORD_W   = 2 * BYTE_W;
  localparam int CH_SEL_W = $clog2(CH_N);

  localparam logic [IDX_W-1:0] IDX_STATUS  = 4'h8;
  localparam logic [IDX_W-1:0] IDX_PTR_CLR = 4'hC;
  localparam logic [IDX_W-1:0] IDX_MCLR    = 4'hD;
  localparam logic [IDX_W-1:0] IDX_UNMASK  = 4'hE;
  localparam logic [IDX_W-1:0] IDX_MASKALL = 4'hF;

  typedef enum logic {HALF_LO = 1'b0, HALF_HI = 1'b1} half_e;
endpackage

// File: rtl/dmr_chan.sv
module dmr_chan
  import dmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we_addr,
  input  logic              we_cnt,
  input  half_e             half,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              eng_ld,
  input  logic [WORD_W-1:0] eng_addr,
  input  logic [WORD_W-1:0] eng_cnt,
  output logic [WORD_W-1:0] base_addr,
  output logic [WORD_W-1:0] base_cnt,
  output logic [WORD_W-1:0] cur_addr,
  output logic [WORD_W-1:0] cur_cnt
);
  function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] w,
                                                 input half_e h,
                                                 input logic [BYTE_W-1:0] b);
    logic [WORD_W-1:0] r;
    r = w;
    if (h == HALF_HI) r[WORD_W-1:BYTE_W] = b;
    else              r[BYTE_W-1:0]      = b;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
    end else begin
      if (eng_ld) begin
        cur_addr <= eng_addr;
        cur_cnt  <= eng_cnt;
      end
      if (we_addr) begin
        base_addr <= put_byte(base_addr, half, wdata);
        cur_addr  <= put_byte(cur_addr, half, wdata);
      end
      if (we_cnt) begin
        base_cnt <= put_byte(base_cnt, half, wdata);
        cur_cnt  <= put_byte(cur_cnt, half, wdata);
      end
    end
  end

  // R4: engine loads never disturb the base copies
  p_eng_keeps_base_r4: assert property (@(posedge clk) disable iff (rst)
    (eng_ld && !we_addr && !we_cnt) |=> ($stable(base_addr) && $stable(base_cnt)));
endmodule

// File: rtl/dmr_ctl.sv
module dmr_ctl
  import dmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [CH_N-1:0]  wbits,
  input  logic [CH_N-1:0]  tc_set,
  output half_e            half,
  output logic [CH_N-1:0]  we_addr,
  output logic [CH_N-1:0]  we_cnt,
  output logic [CH_N-1:0]  mask,
  output logic [CH_N-1:0]  tc
);
  logic reg_hit, do_wr, ptr_clr, mclr, unmask, maskall, stat_rd;
  logic [CH_N-1:0] tc_keep;

  assign reg_hit = sel && (idx < IDX_W'(2 * CH_N));
  assign do_wr   = sel && wr;
  assign ptr_clr = do_wr && (idx == IDX_PTR_CLR);
  assign mclr    = do_wr && (idx == IDX_MCLR);
  assign unmask  = do_wr && (idx == IDX_UNMASK);
  assign maskall = do_wr && (idx == IDX_MASKALL);
  assign stat_rd = sel && !wr && (idx == IDX_STATUS);

  for (genvar n = 0; n < CH_N; n++) begin : g_dec
    assign we_addr[n] = reg_hit && wr && !idx[0] && (idx[CH_SEL_W:1] == CH_SEL_W'(n));
    assign we_cnt[n]  = reg_hit && wr &&  idx[0] && (idx[CH_SEL_W:1] == CH_SEL_W'(n));
  end

  always_ff @(posedge clk) begin
    if (rst)                  half <= HALF_LO;
    else if (ptr_clr || mclr) half <= HALF_LO;
    else if (reg_hit)         half <= (half == HALF_LO) ? HALF_HI : HALF_LO;
  end

  always_ff @(posedge clk) begin
    if (rst)          mask <= '1;
    else if (mclr)    mask <= '1;
    else if (unmask)  mask <= '0;
    else if (maskall) mask <= wbits;
  end

  assign tc_keep = (mclr || stat_rd) ? '0 : tc;

  always_ff @(posedge clk) begin
    if (rst) tc <= '0;
    else     tc <= tc_keep | tc_set;
  end

  p_ptr_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    reg_hit |=> (half != $past(half)));
  p_ptr_clear_r5: assert property (@(posedge clk) disable iff (rst)
    ptr_clr |=> (half == HALF_LO));
  p_mclr_masks_r6: assert property (@(posedge clk) disable iff (rst)
    mclr |=> ((mask == '1) && (half == HALF_LO)));
  p_unmask_r7: assert property (@(posedge clk) disable iff (rst)
    unmask |=> (mask == '0));
  p_stat_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && (tc_set == '0)) |=> (tc == '0));
  p_tc_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (tc_set != '0) |=> ((tc & $past(tc_set)) == $past(tc_set)));
  p_no_ptr_move_r11: assert property (@(posedge clk) disable iff (rst)
    (sel && !reg_hit && !ptr_clr && !mclr) |=> $stable(half));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dmr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_sel,
  input  logic                     bus_wr,
  input  logic [IDX_W-1:0]         bus_idx,
  input  logic [BYTE_W-1:0]        bus_wdata,
  output logic [BYTE_W-1:0]        bus_rdata,
  input  logic [CH_N-1:0]          chan_req,
  input  logic [CH_N-1:0]          tc_set,
  input  logic [CH_N-1:0]          eng_ld,
  input  logic [CH_N*WORD_W-1:0]   eng_addr,
  input  logic [CH_N*WORD_W-1:0]   eng_cnt,
  output logic [CH_N-1:0]          mask_o,
  output logic [CH_N-1:0]          tc_o,
  output logic [CH_N*WORD_W-1:0]   base_addr_o,
  output logic [CH_N*WORD_W-1:0]   base_cnt_o,
  output logic [CH_N*WORD_W-1:0]   cur_addr_o,
  output logic [CH_N*WORD_W-1:0]   cur_cnt_o
);
  half_e             half;
  logic [CH_N-1:0]   we_addr, we_cnt;
  logic [WORD_W-1:0] cur_a [CH_N];
  logic [WORD_W-1:0] cur_c [CH_N];
  logic [WORD_W-1:0] pick;
  logic [BYTE_W-1:0] rd_val;
  logic              rd_stb;

  dmr_ctl u_ctl (
    .clk    (clk),
    .rst    (rst),
    .sel    (bus_sel),
    .wr     (bus_wr),
    .idx    (bus_idx),
    .wbits  (bus_wdata[CH_N-1:0]),
    .tc_set (tc_set),
    .half   (half),
    .we_addr(we_addr),
    .we_cnt (we_cnt),
    .mask   (mask_o),
    .tc     (tc_o)
  );

  for (genvar n = 0; n < CH_N; n++) begin : g_ch
    dmr_chan u_chan (
      .clk      (clk),
      .rst      (rst),
      .we_addr  (we_addr[n]),
      .we_cnt   (we_cnt[n]),
      .half     (half),
      .wdata    (bus_wdata),
      .eng_ld   (eng_ld[n]),
      .eng_addr (eng_addr[n*WORD_W +: WORD_W]),
      .eng_cnt  (eng_cnt[n*WORD_W +: WORD_W]),
      .base_addr(base_addr_o[n*WORD_W +: WORD_W]),
      .base_cnt (base_cnt_o[n*WORD_W +: WORD_W]),
      .cur_addr (cur_a[n]),
      .cur_cnt  (cur_c[n])
    );
    assign cur_addr_o[n*WORD_W +: WORD_W] = cur_a[n];
    assign cur_cnt_o[n*WORD_W +: WORD_W]  = cur_c[n];
  end

  assign rd_stb = bus_sel && !bus_wr;

  always_comb begin
    pick = bus_idx[0] ? cur_c[bus_idx[CH_SEL_W:1]] : cur_a[bus_idx[CH_SEL_W:1]];
    if (bus_idx < IDX_W'(2 * CH_N))
      rd_val = (half == HALF_HI) ? pick[WORD_W-1:BYTE_W] : pick[BYTE_W-1:0];
    else if (bus_idx == IDX_STATUS)
      rd_val = BYTE_W'({chan_req, tc_o});
    else
      rd_val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_stb) bus_rdata <= rd_val;
  end

  p_unimpl_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && (bus_idx > IDX_STATUS)) |=> (bus_rdata == '0));
  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(bus_rdata));
  p_status_view_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && (bus_idx == IDX_STATUS)) |=> (bus_rdata[BYTE_W-1:CH_N] == $past(chan_req)));
endmodule

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]   bus_idx = '0;
  logic [7:0]   bus_wdata = '0;
  logic [7:0]   bus_rdata;
  logic [3:0]   chan_req = '0, tc_set = '0, eng_ld = '0;
  logic [63:0]  eng_addr = '0, eng_cnt = '0;
  logic [3:0]   mask_o, tc_o;
  logic [63:0]  base_addr_o, base_cnt_o, cur_addr_o, cur_cnt_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_fire = 1'b0;

  always #10 clk = ~clk;

  dma_chan_regs uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_idx(bus_idx),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_req(chan_req), .tc_set(tc_set),
    .eng_ld(eng_ld), .eng_addr(eng_addr), .eng_cnt(eng_cnt), .mask_o(mask_o), .tc_o(tc_o),
    .base_addr_o(base_addr_o), .base_cnt_o(base_cnt_o),
    .cur_addr_o(cur_addr_o), .cur_cnt_o(cur_cnt_o)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_idx = idx; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] idx, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_idx = idx;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 0;
  endtask

  always @(posedge clk) rd_fire <= bus_sel && !bus_wr && !rst;

  always @(negedge clk) begin
    if (rd_fire) begin
      if (exp_q.size() == 0) check("monitor: unexpected read result", 16'h1, 16'h0);
      else check(tag_q.pop_front(), {8'h00, bus_rdata}, {8'h00, exp_q.pop_front()});
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R12 reset masks", {12'h0, mask_o}, 16'h000F);
    check("R12 reset tc", {12'h0, tc_o}, 16'h0000);
    check("R12 reset rdata", {8'h0, bus_rdata}, 16'h0000);
    check("R12 reset addr", cur_addr_o[15:0], 16'h0000);
    rd(4'h8, 8'h00, "R12 status after reset");

    // R1 R3: program channel 1 address, channel 3 count
    wr(4'h2, 8'h34); wr(4'h2, 8'h12);
    check("R1 R3 ch1 base addr", base_addr_o[31:16], 16'h1234);
    check("R3 ch1 cur addr", cur_addr_o[31:16], 16'h1234);
    wr(4'h7, 8'hCD); wr(4'h7, 8'hAB);
    check("R1 ch3 base cnt", base_cnt_o[63:48], 16'hABCD);
    check("R1 ch3 addr untouched", base_addr_o[63:48], 16'h0000);
    check("R1 ch1 cnt untouched", base_cnt_o[31:16], 16'h0000);
    rd(4'h2, 8'h34, "R2 R4 ch1 addr low");
    rd(4'h2, 8'h12, "R2 R4 ch1 addr high");

    // R2: pointer shared across channels and read/write
    wr(4'h0, 8'h11);
    rd(4'h2, 8'h12, "R2 shared pointer gives high byte");
    check("R3 ch0 low byte only", base_addr_o[15:0], 16'h0011);

    // R5: pointer clear
    wr(4'h4, 8'h55); wr(4'hC, 8'h00); wr(4'h4, 8'h66);
    check("R5 pointer clear returns low byte", base_addr_o[47:32], 16'h0066);
    wr(4'h4, 8'h00);

    // R11: unimplemented indices
    wr(4'h0, 8'h77);
    rd(4'hA, 8'h00, "R11 read index A");
    rd(4'hE, 8'h00, "R11 read index E");
    wr(4'h9, 8'hFF);
    wr(4'h0, 8'h88);
    check("R11 pointer not moved", base_addr_o[15:0], 16'h8877);
    check("R11 masks unchanged", {12'h0, mask_o}, 16'h000F);

    // R4: engine load
    @(negedge clk);
    eng_ld = 4'b0010; eng_addr[31:16] = 16'hBEEF; eng_cnt[31:16] = 16'h0042;
    @(negedge clk);
    eng_ld = '0;
    check("R4 cur addr from engine", cur_addr_o[31:16], 16'hBEEF);
    check("R4 base addr kept", base_addr_o[31:16], 16'h1234);
    rd(4'h2, 8'hEF, "R4 read current low");
    rd(4'h2, 8'hBE, "R4 read current high");
    rd(4'h3, 8'h42, "R4 read current cnt low");
    rd(4'h3, 8'h00, "R4 read current cnt high");

    // R7 R8: masks
    wr(4'hF, 8'hF5);
    check("R8 mask load", {12'h0, mask_o}, 16'h0005);
    wr(4'hE, 8'h00);
    check("R7 unmask all", {12'h0, mask_o}, 16'h0000);
    wr(4'hF, 8'h0A);
    check("R8 mask load 2", {12'h0, mask_o}, 16'h000A);

    // R9 R10: terminal count and status
    @(negedge clk); tc_set = 4'b0011;
    @(negedge clk); tc_set = '0;
    check("R10 tc set", {12'h0, tc_o}, 16'h0003);
    chan_req = 4'b1001;
    rd(4'h8, 8'h93, "R9 status value");
    check("R9 status clears tc", {12'h0, tc_o}, 16'h0000);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_idx = 4'h8; tc_set = 4'b0100;
    exp_q.push_back(8'h90); tag_q.push_back("R9 R10 status with coincident set");
    @(negedge clk);
    bus_sel = 0; tc_set = '0;
    check("R10 set beats status clear", {12'h0, tc_o}, 16'h0004);
    repeat (3) @(negedge clk);
    check("R13 rdata holds", {8'h0, bus_rdata}, 16'h0090);

    // R6: master clear
    wr(4'h6, 8'h01);
    wr(4'hD, 8'h00);
    check("R6 masks set", {12'h0, mask_o}, 16'h000F);
    check("R6 tc cleared", {12'h0, tc_o}, 16'h0000);
    wr(4'h6, 8'h02);
    check("R6 pointer cleared", base_addr_o[63:48], 16'h0002);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) check("monitor: pending reads", 16'(exp_q.size()), 16'h0);
    summary();
  end
endmodule